// File: doc/BRIEF.md
# Random Replacement Slot Picker

This block hands out a pseudo-random slot number for a translation buffer whose replacement policy is random. The slots below a software-set floor are reserved and must never be chosen. The floor is supplied on every request. The block keeps a 32-bit linear congruential state. Each request moves that state one step forward. The upper half of the new state is then folded into the permitted range of slots: the floor itself up to the last slot.

A client pulses `pick_req` for one cycle, or holds it high to get one pick per cycle. It presents the current floor on `floor_in` in the same cycle. On the next cycle `slot_valid` is high and `slot_out` carries the chosen slot. When no request is made, the state does not move, so the sequence depends only on how many picks have been made since reset. A floor at or above the slot count leaves no free slot. In that case the block returns the last slot and does not divide by zero.

The control is a two-state machine:
- `ST_IDLE` means no pick was made on the previous edge.
- `ST_ISSUE` means a pick was made on the previous edge and the result is on the outputs.

The transitions are:
- **start**: `ST_IDLE` to `ST_ISSUE` when `pick_req` is high.
- **stream**: `ST_ISSUE` stays in `ST_ISSUE` while `pick_req` stays high.
- **drain**: `ST_ISSUE` to `ST_IDLE` when `pick_req` is low.
- **rest**: `ST_IDLE` stays in `ST_IDLE` when `pick_req` is low.

`slot_valid` is high exactly when the machine is in `ST_ISSUE`.

Top module: `repl_index_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state is cleared to zero, the machine enters `ST_IDLE`, `slot_valid` goes to 0 and `slot_out` goes to 0.
- R2: A clock edge that samples `pick_req` high replaces the state with (state × 314159 + 1) mod 2^32. After reset, the first two states are therefore 1 and 314160.
- R3: The state and `slot_out` are unchanged by any edge that samples `pick_req` low. Idle cycles do not alter the later sequence of slots.
- R4: With `floor_in` < ENTRIES, the slot is (new_state[31:16] mod (ENTRIES − floor_in)) + floor_in. Here new_state is the state after the step that this request caused.
- R5: For a request with `floor_in` < ENTRIES, `slot_out` is never below `floor_in` and never above ENTRIES − 1.
- R6: With `floor_in` ≥ ENTRIES, `slot_out` is ENTRIES − 1. The state still takes its step.
- R7: `slot_valid` is high in the cycle after each edge that samples `pick_req` high, and low in every other cycle. `slot_out` is updated on that same edge. The machine follows the start, stream, drain and rest transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pick_req | input | 1 | Request one slot pick this cycle |
| floor_in | input | $clog2(ENTRIES)+1 | Lowest slot that may be picked; values ≥ ENTRIES mean no slot is free |
| slot_out | output | $clog2(ENTRIES) | Picked slot, registered |
| slot_valid | output | 1 | High for one cycle per request, one cycle after it |

## Verification
The assertions assume that `floor_in` is stable and meaningful only in a cycle where `pick_req` is high. They relate the floor sampled with a request to the slot returned on the next cycle. They make no claim about the floor in idle cycles. They also assume `pick_req` is never X after reset. The stimulus sets `floor_in` at the same negative edge as `pick_req`, holds both through the sampling edge, and drops the request before changing the floor for idle spans. Every floor value is drawn from the full input range, including values at and beyond the slot count.

// File: rtl/repl_index_pkg.sv
package repl_index_pkg;

    localparam int STATE_W = 32;
    localparam int HALF_W  = STATE_W / 2;

    localparam logic [STATE_W-1:0] LCG_MUL = 32'd314159;
    localparam logic [STATE_W-1:0] LCG_INC = 32'd1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } pick_fsm_e;

endpackage

// File: rtl/lcg_step.sv
module lcg_step
    import repl_index_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    output logic [STATE_W-1:0] state_nxt
);

    logic [STATE_W-1:0] state_q;

    // Next value of the recurrence, offered combinationally so the
    // folder sees the stepped state in the request cycle.
    always_comb begin
        state_nxt = state_q * LCG_MUL + LCG_INC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (advance) begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/range_fold.sv
module range_fold
    import repl_index_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int WIRED_W = IDX_W + 1
) (
    input  logic [STATE_W-1:0] state_in,
    input  logic [WIRED_W-1:0] floor_in,
    output logic [IDX_W-1:0]   slot
);

    localparam logic [WIRED_W-1:0] ENTRIES_W = WIRED_W'(ENTRIES);
    localparam logic [IDX_W-1:0]   LAST_SLOT = IDX_W'(ENTRIES - 1);

    logic [HALF_W-1:0]  upper;
    logic [WIRED_W-1:0] span;
    logic [HALF_W-1:0]  rem;

    always_comb begin
        upper = HALF_W'(state_in >> HALF_W);
        span  = '0;
        rem   = '0;
        if (floor_in >= ENTRIES_W) begin
            slot = LAST_SLOT;
        end else begin
            span = ENTRIES_W - floor_in;
            rem  = upper % HALF_W'(span);
            slot = IDX_W'(rem + HALF_W'(floor_in));
        end
    end

endmodule

// File: rtl/repl_index_gen.sv
module repl_index_gen
    import repl_index_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int WIRED_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pick_req,
    input  logic [WIRED_W-1:0] floor_in,
    output logic [IDX_W-1:0]   slot_out,
    output logic               slot_valid
);

    pick_fsm_e          cur_st;
    pick_fsm_e          nxt_st;
    logic [STATE_W-1:0] stepped;
    logic [IDX_W-1:0]   folded;

    lcg_step u_lcg (
        .clk       (clk),
        .rst       (rst),
        .advance   (pick_req),
        .state_nxt (stepped)
    );

    range_fold #(.ENTRIES(ENTRIES)) u_fold (
        .state_in (stepped),
        .floor_in (floor_in),
        .slot     (folded)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st <= ST_IDLE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Transitions: start, stream, drain, rest
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE:  nxt_st = pick_req ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: nxt_st = pick_req ? ST_ISSUE : ST_IDLE;
            default:  nxt_st = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_out <= '0;
        end else if (pick_req) begin
            slot_out <= folded;
        end
    end

    assign slot_valid = (cur_st == ST_ISSUE);

endmodule

// File: rtl/repl_index_gen_chk.sv
module repl_index_gen_chk #(
    parameter int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int WIRED_W = IDX_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               pick_req,
    input logic [WIRED_W-1:0] floor_in,
    input logic [IDX_W-1:0]   slot_out,
    input logic               slot_valid
);

    localparam logic [WIRED_W-1:0] ENTRIES_W = WIRED_W'(ENTRIES);
    localparam logic [IDX_W-1:0]   LAST_SLOT = IDX_W'(ENTRIES - 1);

    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (rst)
        pick_req |=> slot_valid);

    p_quiet_without_req_r7: assert property (@(posedge clk) disable iff (rst)
        !pick_req |=> !slot_valid);

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !pick_req |=> $stable(slot_out));

    p_floor_respected_r5: assert property (@(posedge clk) disable iff (rst)
        (pick_req && floor_in < ENTRIES_W) |=> ({1'b0, slot_out} >= $past(floor_in)));

    p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
        (pick_req && floor_in >= ENTRIES_W) |=> (slot_out == LAST_SLOT));

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!slot_valid && slot_out == '0));

endmodule

bind repl_index_gen repl_index_gen_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pick_req   (pick_req),
    .floor_in   (floor_in),
    .slot_out   (slot_out),
    .slot_valid (slot_valid)
);

// File: tb/test_repl_index_gen.sv
module test_repl_index_gen;

    localparam int N     = 16;
    localparam int IW    = $clog2(N);
    localparam int WW    = IW + 1;
    localparam int NVEC  = 10;

    // Table columns: floor for the burst, burst length, idle cycles after.
    localparam int VEC_FLOOR [NVEC] = '{0, 3, 7, 15, 16, 1, 31, 9, 0, 12};
    localparam int VEC_LEN   [NVEC] = '{300, 250, 200, 120, 80, 400, 60, 300, 500, 250};
    localparam int VEC_GAP   [NVEC] = '{2, 5, 1, 3, 4, 0, 2, 6, 3, 2};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pick_req = 1'b0;
    logic [WW-1:0] floor_in = '0;
    logic [IW-1:0] slot_out;
    logic          slot_valid;

    int unsigned   errors = 0;
    int unsigned   checks = 0;
    logic [31:0]   seed = '0;
    int unsigned   exp_slot = 0;

    repl_index_gen #(.ENTRIES(N)) i_repl_index_gen (
        .clk        (clk),
        .rst        (rst),
        .pick_req   (pick_req),
        .floor_in   (floor_in),
        .slot_out   (slot_out),
        .slot_valid (slot_valid)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Independent model: step the recurrence, then fold into range.
    task automatic model_pick(input int unsigned fl);
        seed = seed * 32'd314159 + 32'd1;
        if (fl >= N) exp_slot = N - 1;
        else exp_slot = ((seed >> 16) % (N - fl)) + fl;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check_result(input string tag, input int unsigned fl);
        check({tag, " valid (R7)"}, slot_valid, 1);
        check({tag, " slot (R4/R6)"}, slot_out, exp_slot);
        if (fl < N) begin
            checks++;
            if (slot_out < fl || slot_out > N - 1) begin
                errors++;
                $display("FAIL R5: actual=%0d expected range %0d..%0d", slot_out, fl, N - 1);
            end
        end
    endtask

    task automatic burst(input int unsigned fl, input int unsigned len, input string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) check_result(tag, fl);
            pick_req = 1'b1;
            floor_in = WW'(fl);
            model_pick(fl);
        end
        @(negedge clk);
        check_result(tag, fl);
        pick_req = 1'b0;
    endtask

    task automatic idle(input int unsigned n, input string tag);
        for (int i = 0; i < n; i++) begin
            floor_in = WW'(i * 5);
            @(negedge clk);
            check({tag, " idle valid low (R7)"}, slot_valid, 0);
            check({tag, " idle slot held (R3)"}, slot_out, exp_slot);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset valid", slot_valid, 0);
        check("R1 reset slot", slot_out, 0);
        rst = 1'b0;

        // R2: first two steps give states 1 and 314160 -> slots 0 and 4
        burst(0, 1, "R2 first");
        check("R2 first slot literal", slot_out, 0);
        burst(0, 1, "R2 second");
        check("R2 second slot literal", slot_out, 4);

        // R3: idle cycles leave sequence untouched
        idle(7, "R3");
        burst(2, 3, "R3 resume");

        // R6: saturation at and above the slot count, state still steps
        burst(16, 1, "R6 floor16");
        check("R6 floor16 literal", slot_out, N - 1);
        burst(31, 1, "R6 floor31");
        burst(15, 2, "R6 floor15");
        burst(4, 2, "R6 after");

        // Table walk: R4, R5, R7
        for (int v = 0; v < NVEC; v++) begin
            burst(VEC_FLOOR[v], VEC_LEN[v], "R4 table");
            idle(VEC_GAP[v], "R4 table");
        end

        // R1: reset mid-run restarts the sequence
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset valid", slot_valid, 0);
        check("R1 mid reset slot", slot_out, 0);
        rst = 1'b0;
        seed = '0;
        exp_slot = 0;
        burst(5, 1, "R1 restart");
        check("R1 restart literal", slot_out, 5);
        idle(2, "R7 tail");

        finish_run();
    end

endmodule